// File: doc/BRIEF.md
# SPI Output-Driver Fault Poller

This block reads fault status from three low-side output driver chips that share one SPI bus. Each driver has its own active-low select. A poll starts on a one-cycle start strobe. The block then selects the drivers one after another. Under each select it runs two full-duplex byte transfers back to back. The byte clocked in by the first transfer carries open-load flags, and the byte clocked in by the second carries short-circuit flags. Each received byte is OR-merged into a sticky register for that driver and fault class. The result is six sticky registers, and each one is cleared by its own strobe.

A poll is dropped when it is requested while another SPI frame already owns the bus, or while the supply is flagged low. In that case no select is asserted and the completion pulse comes straight away. The block is the SPI master and contains its own shifter. The clock polarity, the clock phase (default CPOL=0, CPHA=1) and the clock divider are parameters. The bytes it shifts out carry no meaning; they exist only so that status can be clocked in.

Top module: `spi_fault_poller`

## Requirements
- R1: A start strobe taken while `bus_busy_i` is high asserts no select. `done_o` pulses in the cycle after the start edge, and every sticky register keeps its value.
- R2: A start strobe taken while `batt_low_i` is high behaves the same way as in R1: no select, a `done_o` pulse in the next cycle, and no register change.
- R3: An accepted poll pulls `cs_no[0]`, then `cs_no[1]`, then `cs_no[2]` low, each exactly once. No two selects are low at the same time.
- R4: The first byte received under select d is OR-ed into `open_flt_o[8*d +: 8]`.
- R5: The second byte received under select d is OR-ed into `short_flt_o[8*d +: 8]`.
- R6: A sticky bit stays set until the clear strobe for its own register. A clear strobe in a cycle with no update zeroes only that one register.
- R7: When a clear strobe and an OR-update hit the same register in the same cycle, the register takes exactly the newly received byte.
- R8: `sclk_o` rests at CPOL (0 by default) whenever every select is high. Bytes are received MSB first. In the default mode the slave drives on the rising edge and the master samples on the falling edge.
- R9: A select stays low across both transfers. Between one select rising and the next one falling, all selects stay high for at least one SCLK period (2*CLK_DIV clock cycles).
- R10: `done_o` is a one-cycle pulse. For an accepted poll it rises in the cycle in which the third select rises, 2*(3+34*CLK_DIV)+3+32*CLK_DIV clock edges after the start edge. `busy_o` is high in between.
- R11: A start strobe that arrives while `busy_o` is high is ignored. It changes neither the timing nor the number of `done_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Poll request strobe |
| bus_busy_i | input | 1 | Another SPI frame is in progress |
| batt_low_i | input | 1 | Supply-low inhibit |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data out (fill pattern) |
| miso_i | input | 1 | SPI data in |
| cs_no | output | 3 | Per-driver active-low selects |
| open_flt_o | output | 24 | Sticky open-load flags, 8 bits per driver |
| short_flt_o | output | 24 | Sticky short-circuit flags, 8 bits per driver |
| clr_open_i | input | 3 | Per-driver clear of the open-load register |
| clr_short_i | input | 3 | Per-driver clear of the short-circuit register |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | Poll finished or skipped (one cycle) |

## Verification
The assertions watch properties that hold on every cycle:
- at most one select is low;
- the clock rests at its idle level whenever no driver is selected;
- a sticky register never loses a bit without a clear;
- a clear coinciding with an update leaves exactly the new byte;
- a dropped poll answers on the next cycle with every select high;
- `done_o` never lasts two cycles.

Only the bench scenarios can show the end-to-end behaviour:
- a slave model's bytes arrive MSB first in the right driver's open and short registers;
- the selects fall in order with the required gap;
- the total poll latency is exact;
- an overlapping start strobe changes nothing.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_BYTE0,
    ST_BYTE1,
    ST_GAP
  } seq_state_e;
endpackage

// File: rtl/sfp_spi_shifter.sv
module sfp_spi_shifter #(
  parameter int unsigned DW      = 8,
  parameter int unsigned CLK_DIV = 4,
  parameter bit          CPOL    = 1'b0,
  parameter bit          CPHA    = 1'b1,
  parameter logic [DW-1:0] TX_FILL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          miso_i,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o
);
  localparam int unsigned EDGES  = 2 * DW;
  localparam int unsigned DIV_W  = $clog2(CLK_DIV + 1);
  localparam int unsigned EDGE_W = $clog2(EDGES + 1);
  // extra top bit lets CPHA=1 launch its first bit on the leading edge
  localparam logic [DW:0] TX_INIT = CPHA ? {1'b0, TX_FILL} : {TX_FILL, 1'b0};

  logic              active_q, sclk_q, done_q;
  logic [DIV_W-1:0]  div_q;
  logic [EDGE_W-1:0] edge_q;
  logic [DW-1:0]     rx_q;
  logic [DW:0]       tx_q;
  logic              lead_edge, samp_edge;

  assign lead_edge = ~edge_q[0];
  assign samp_edge = CPHA ? ~lead_edge : lead_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= CPOL;
      done_q   <= 1'b0;
      div_q    <= '0;
      edge_q   <= '0;
      rx_q     <= '0;
      tx_q     <= TX_INIT;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          div_q    <= '0;
          edge_q   <= '0;
          tx_q     <= TX_INIT;
        end
      end else if (div_q == DIV_W'(CLK_DIV - 1)) begin
        div_q  <= '0;
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 1'b1;
        if (samp_edge) rx_q <= {rx_q[DW-2:0], miso_i};
        else           tx_q <= {tx_q[DW-1:0], 1'b0};
        if (edge_q == EDGE_W'(EDGES - 1)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[DW];
  assign done_o = done_q;
  assign rx_o   = rx_q;

  // R8
  clk_idle_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (sclk_q == CPOL));
  // R8
  clk_idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> (sclk_q == CPOL));
endmodule

// File: rtl/sfp_seq.sv
module sfp_seq
  import sfp_pkg::*;
#(
  parameter int unsigned NUM_DRV = 3,
  parameter int unsigned GAP_CYC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               bus_busy_i,
  input  logic               batt_low_i,
  input  logic               xfer_done_i,
  output logic               xfer_start_o,
  output logic [NUM_DRV-1:0] cs_no,
  output logic [NUM_DRV-1:0] wr_open_o,
  output logic [NUM_DRV-1:0] wr_short_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int unsigned DRV_W = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1;
  localparam int unsigned GAP_W = $clog2(GAP_CYC + 1);

  seq_state_e         state_q;
  logic [DRV_W-1:0]   drv_q;
  logic [GAP_W-1:0]   gap_q;
  logic [NUM_DRV-1:0] cs_n_q;
  logic               done_q;
  logic               inhibit;

  assign inhibit      = bus_busy_i | batt_low_i;
  assign xfer_start_o = (state_q == ST_ARM) | ((state_q == ST_BYTE0) & xfer_done_i);
  assign busy_o       = (state_q != ST_IDLE);

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_wr
    assign wr_open_o[d]  = (state_q == ST_BYTE0) && xfer_done_i && (drv_q == DRV_W'(d));
    assign wr_short_o[d] = (state_q == ST_BYTE1) && xfer_done_i && (drv_q == DRV_W'(d));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      drv_q   <= '0;
      gap_q   <= '0;
      cs_n_q  <= '1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (inhibit) begin
            done_q <= 1'b1;
          end else begin
            drv_q   <= '0;
            cs_n_q  <= ~NUM_DRV'(1);
            state_q <= ST_ARM;
          end
        end
        ST_ARM:   state_q <= ST_BYTE0;
        ST_BYTE0: if (xfer_done_i) state_q <= ST_BYTE1;
        ST_BYTE1: if (xfer_done_i) begin
          cs_n_q <= '1;
          if (drv_q == DRV_W'(NUM_DRV - 1)) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            gap_q   <= '0;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_W'(GAP_CYC - 1)) begin
            drv_q   <= drv_q + 1'b1;
            cs_n_q  <= ~(NUM_DRV'(1) << (drv_q + 1'b1));
            state_q <= ST_ARM;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no  = cs_n_q;
  assign done_o = done_q;

  // R3
  one_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_q));
  // R1
  skip_no_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && inhibit) |=> (done_q && (&cs_n_q)));
  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R9
  select_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BYTE0 && xfer_done_i) |=> $stable(cs_n_q));
endmodule

// File: rtl/sfp_sticky.sv
module sfp_sticky #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          clr_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (clr_i)   q_q <= we_i ? din_i : '0;
    else if (we_i)    q_q <= q_q | din_i;
  end

  assign q_o = q_q;

  // R6
  no_bit_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((q_o & $past(q_o)) == $past(q_o)));
  // R6
  clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !we_i) |=> (q_o == '0));
  // R7
  clear_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && we_i) |=> (q_o == $past(din_i)));
endmodule

// File: rtl/spi_fault_poller.sv
module spi_fault_poller #(
  parameter int unsigned NUM_DRV = 3,
  parameter int unsigned DW      = 8,
  parameter int unsigned CLK_DIV = 4,
  parameter bit          CPOL    = 1'b0,
  parameter bit          CPHA    = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  bus_busy_i,
  input  logic                  batt_low_i,
  output logic                  sclk_o,
  output logic                  mosi_o,
  input  logic                  miso_i,
  output logic [NUM_DRV-1:0]    cs_no,
  output logic [NUM_DRV*DW-1:0] open_flt_o,
  output logic [NUM_DRV*DW-1:0] short_flt_o,
  input  logic [NUM_DRV-1:0]    clr_open_i,
  input  logic [NUM_DRV-1:0]    clr_short_i,
  output logic                  busy_o,
  output logic                  done_o
);
  localparam int unsigned GAP_CYC = 2 * CLK_DIV;

  logic               xfer_start, xfer_done;
  logic [DW-1:0]      rx_byte;
  logic [NUM_DRV-1:0] wr_open, wr_short;

  sfp_seq #(.NUM_DRV(NUM_DRV), .GAP_CYC(GAP_CYC)) u_seq (
    .clk_i, .rst_ni, .start_i, .bus_busy_i, .batt_low_i,
    .xfer_done_i (xfer_done),
    .xfer_start_o(xfer_start),
    .cs_no,
    .wr_open_o   (wr_open),
    .wr_short_o  (wr_short),
    .busy_o, .done_o
  );

  sfp_spi_shifter #(.DW(DW), .CLK_DIV(CLK_DIV), .CPOL(CPOL), .CPHA(CPHA)) u_shift (
    .clk_i, .rst_ni,
    .start_i(xfer_start),
    .miso_i,
    .sclk_o, .mosi_o,
    .done_o (xfer_done),
    .rx_o   (rx_byte)
  );

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    sfp_sticky #(.DW(DW)) u_open (
      .clk_i, .rst_ni,
      .we_i (wr_open[d]), .clr_i(clr_open_i[d]), .din_i(rx_byte),
      .q_o  (open_flt_o[d*DW +: DW])
    );
    sfp_sticky #(.DW(DW)) u_short (
      .clk_i, .rst_ni,
      .we_i (wr_short[d]), .clr_i(clr_short_i[d]), .din_i(rx_byte),
      .q_o  (short_flt_o[d*DW +: DW])
    );
  end

  // R8
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_no) |-> (sclk_o == CPOL));
  // R4
  write_under_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_open | wr_short) != '0) |-> (((wr_open | wr_short) & cs_no) == '0));
endmodule

// File: tb/spi_fault_poller_bench.sv
module spi_fault_poller_bench;
  localparam int D   = 4;
  localparam int LAT = 2 * (3 + 34 * D) + 3 + 32 * D;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, bus_busy = 0, batt_low = 0, miso = 0;
  logic sclk, mosi, busy, done;
  logic [2:0]  cs_n, clr_open = 0, clr_short = 0;
  logic [23:0] open_flt, short_flt;

  always #10 clk = ~clk;

  spi_fault_poller #(.CLK_DIV(D)) u_spi_fault_poller (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bus_busy_i(bus_busy),
    .batt_low_i(batt_low), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso),
    .cs_no(cs_n), .open_flt_o(open_flt), .short_flt_o(short_flt),
    .clr_open_i(clr_open), .clr_short_i(clr_short), .busy_o(busy), .done_o(done)
  );

  int checks = 0, failures = 0;
  logic [7:0] opn [3], sht [3], exp_o [3], exp_s [3];

  // slave model: mode CPOL=0/CPHA=1, drives on rising SCLK, open byte then short byte
  logic [15:0] sl_sr;
  wire sel_act = ~&cs_n;
  always @(posedge sel_act) begin
    for (int d = 0; d < 3; d++) if (!cs_n[d]) sl_sr = {opn[d], sht[d]};
    miso = 1'b0;
  end
  always @(posedge sclk) if (sel_act) begin
    miso  = sl_sr[15];
    sl_sr = sl_sr << 1;
  end

  // select monitor
  int log_idx [8];
  int nsel = 0, multi = 0, gap_cnt = 0, gap_bad = 0, done_cnt = 0, sclk_bad = 0;
  logic seen_rise = 0;
  logic [2:0] prev_cs = '1;
  always @(negedge clk) begin
    if ($countones(~cs_n) > 1) multi++;
    if ((&cs_n) && sclk) sclk_bad++;
    if (done) done_cnt++;
    for (int d = 0; d < 3; d++) begin
      if (prev_cs[d] && !cs_n[d]) begin
        if (nsel < 8) log_idx[nsel] = d;
        nsel++;
        if (seen_rise && gap_cnt < 2 * D) gap_bad++;
      end
      if (!prev_cs[d] && cs_n[d]) begin seen_rise = 1; gap_cnt = 0; end
    end
    if (&cs_n) gap_cnt++;
    prev_cs = cs_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int d = 0; d < 3; d++) begin
      chk(open_flt[d*8 +: 8] == exp_o[d], {tag, " R4 open"}, open_flt[d*8 +: 8], exp_o[d]);
      chk(short_flt[d*8 +: 8] == exp_s[d], {tag, " R5 short"}, short_flt[d*8 +: 8], exp_s[d]);
    end
  endtask

  task automatic clear_reg(input bit is_short, input int d);
    @(negedge clk);
    if (is_short) clr_short[d] = 1'b1; else clr_open[d] = 1'b1;
    @(negedge clk);
    clr_short = '0; clr_open = '0;
    if (is_short) exp_s[d] = '0; else exp_o[d] = '0;
  endtask

  task automatic run_poll(input bit collide, input bit restart);
    int lat;
    nsel = 0; multi = 0; gap_bad = 0; done_cnt = 0; seen_rise = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 0;
    while (!done && lat < 2000) begin
      if (collide && lat == 1 + 16 * D) clr_open[0] = 1'b1;
      if (collide && lat == 2 + 16 * D) clr_open[0] = 1'b0;
      if (restart && lat == 100) start = 1'b1;
      if (restart && lat == 101) start = 1'b0;
      @(negedge clk); lat++;
    end
    clr_open = '0; start = 1'b0;
    // R10
    chk(lat == LAT, "R10 done latency", lat, LAT);
    @(negedge clk);
    chk(done_cnt == 1, "R10/R11 single done", done_cnt, 1);
    chk(!busy, "R10 busy cleared", busy, 0);
    // R3
    chk(nsel == 3 && log_idx[0] == 0 && log_idx[1] == 1 && log_idx[2] == 2 && multi == 0,
        "R3 select order", nsel, 3);
    // R9
    chk(gap_bad == 0, "R9 select gap", gap_bad, 0);
    // R8
    chk(sclk_bad == 0 && sclk == 1'b0, "R8 sclk idle", sclk_bad, 0);
    for (int d = 0; d < 3; d++) begin
      exp_o[d] = (collide && d == 0) ? opn[d] : (exp_o[d] | opn[d]);
      exp_s[d] = exp_s[d] | sht[d];
    end
    check_regs(collide ? "R7 collide" : "poll");
  endtask

  task automatic skip_poll(input bit use_batt, input string tag);
    nsel = 0; done_cnt = 0;
    @(negedge clk);
    if (use_batt) batt_low = 1'b1; else bus_busy = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; bus_busy = 1'b0; batt_low = 1'b0;
    chk(done == 1'b1, {tag, " done next cycle"}, done, 1);
    repeat (3) @(negedge clk);
    chk(nsel == 0 && (&cs_n), {tag, " no select"}, nsel, 0);
    chk(done_cnt == 1, {tag, " single done"}, done_cnt, 1);
    check_regs(tag);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int d = 0; d < 3; d++) begin exp_o[d] = 0; exp_s[d] = 0; opn[d] = 0; sht[d] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 3'b111 && !busy && !done && !sclk, "reset outputs", {cs_n, busy, done, sclk}, 6'b111000);
    check_regs("reset");

    // directed MSB-first patterns
    opn[0] = 8'h80; sht[0] = 8'h01; opn[1] = 8'h01; sht[1] = 8'h80; opn[2] = 8'hA5; sht[2] = 8'h3C;
    run_poll(0, 0);
    // R6 sticky OR with new bits
    opn[0] = 8'h01; sht[0] = 8'h00; opn[1] = 8'h10; sht[1] = 8'h02; opn[2] = 8'h00; sht[2] = 8'hC0;
    run_poll(0, 0);
    // R6 single-register clear
    clear_reg(1, 1);
    @(negedge clk);
    check_regs("R6 clear short1");
    clear_reg(0, 2);
    @(negedge clk);
    check_regs("R6 clear open2");
    // R1, R2 skipped polls
    skip_poll(0, "R1 bus busy");
    skip_poll(1, "R2 battery low");
    // R7 clear coinciding with update
    opn[0] = 8'h42; sht[0] = 8'h00; opn[1] = 8'h00; sht[1] = 8'h00; opn[2] = 8'h00; sht[2] = 8'h00;
    run_poll(1, 0);
    // R11 overlapping start ignored
    opn[0] = 8'h08; opn[1] = 8'h20; opn[2] = 8'h04; sht[0] = 8'h10; sht[1] = 8'h40; sht[2] = 8'h01;
    run_poll(0, 1);

    for (int it = 0; it < 8; it++) begin
      for (int d = 0; d < 3; d++) begin
        opn[d] = 8'($urandom); sht[d] = 8'($urandom);
        if (($urandom % 4) == 0) opn[d] = '0;
      end
      if (($urandom % 3) == 0) clear_reg($urandom % 2, $urandom % 3);
      if (($urandom % 4) == 0) skip_poll($urandom % 2, "R1/R2 random skip");
      run_poll(($urandom % 4) == 0, ($urandom % 3) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule